// File: doc/BRIEF.md
# Parallel NOR Flash Command Sequencer

This block models the command side of a small parallel NOR flash. A host drives single-cycle write and read strobes with an address and a byte of data. Writes are matched against multi-write unlock sequences. A completed sequence starts a timed internal operation on a register-based byte array: a word program, a chip erase or a sector erase. While that operation runs, the busy output is high, bus writes are ignored, and reads return a status byte instead of array contents. When the operation finishes, the block returns to plain array reads.

Programming can only clear bits. Erase first fills its region with zeros and then with ones, one word per cycle. The synchronous reset acts as the hardware reset: it stops any running operation at once and leaves the array in whatever partial state that operation had reached.

Top module: `nor_flash_seq`

## Requirements
- R1: After reset, busy is 0 and a read returns the array word at the read address.
- R2: The writes 0xAA@0x555, 0x55@0x2AA, 0xA0@0x555, then any data D at word address A, set word A to (old AND D): bits only go 1 to 0, at any address and in any order.
- R3: busy rises only after an accepted command write. It stays high for exactly PROG_CYC cycles for a program, and for 2*N+ERASE_CYC cycles for an erase of N words.
- R4: The writes 0xAA@0x555, 0x55@0x2AA, 0x80@0x555, 0xAA@0x555, 0x55@0x2AA, 0x10@0x555 erase the whole array to 0xFF.
- R5: The same five-write prefix followed by 0x30 at any address erases only the sector selected by the top SEC_W bits of the word address to 0xFF. Other sectors are unchanged.
- R6: While busy is high, every bus write is ignored. A complete program sequence issued during busy has no effect, and the decoder is still idle afterwards.
- R7: A read while busy returns status. Bit 7 is the complement of bit 7 of the program data, or 0 during an erase. Bit 6 inverts on every busy read. Bit 2 inverts on every busy read during an erase and holds during a program. All other bits are 0.
- R8: A write that does not match the expected step returns the decoder to idle, and the data write that follows does not program. Data 0xF0 at the program data step cancels the program, and the next valid sequence works.
- R9: Reset during an operation drops busy on the next cycle. Words the erase had already zero-filled (in ascending order from the region base) read 0x00, and later words are untouched. A reissued command then completes normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| bus_we | input | 1 | Write strobe, one cycle per bus write |
| bus_re | input | 1 | Read strobe, one cycle per bus read |
| bus_addr | input | AW | Bus word address |
| bus_wdata | input | 8 | Write data / command byte |
| bus_rdata | output | 8 | Array data or status, valid the cycle after a read strobe |
| busy | output | 1 | High while an embedded operation runs |

## Verification
The bench probes the 0 to 1 program case. A design that wrote the data directly would read back set bits. It breaks sequences mid-stream and cancels with 0xF0; a decoder that lingered in a partial state would program on a stray write. It fires a whole program sequence during a sector erase, which a design that kept decoding while busy would act on once the erase ends. It pulls reset three cycles into an erase and expects exactly the first words zeroed. It counts busy cycles against the formula, so an off-by-one in the wait or walk counters shows as a wrong length.

// File: rtl/nor_seq_pkg.sv
package nor_seq_pkg;
  localparam int BYTE_W = 8;
  localparam int CMD_AW = 11;

  localparam logic [CMD_AW-1:0] ADR_KEY1 = 11'h555;
  localparam logic [CMD_AW-1:0] ADR_KEY2 = 11'h2AA;

  localparam logic [BYTE_W-1:0] KEY1     = 8'hAA;
  localparam logic [BYTE_W-1:0] KEY2     = 8'h55;
  localparam logic [BYTE_W-1:0] OP_PROG  = 8'hA0;
  localparam logic [BYTE_W-1:0] OP_ESET  = 8'h80;
  localparam logic [BYTE_W-1:0] OP_CHIP  = 8'h10;
  localparam logic [BYTE_W-1:0] OP_SECT  = 8'h30;
  localparam logic [BYTE_W-1:0] OP_ABORT = 8'hF0;

  typedef enum logic [2:0] {
    DS_IDLE, DS_K1, DS_K2, DS_PADDR, DS_ESET, DS_EK1, DS_EK2
  } dec_state_e;

  typedef enum logic [2:0] {
    ES_IDLE, ES_PWAIT, ES_ZERO, ES_EWAIT, ES_ONE
  } eng_state_e;
endpackage

// File: rtl/nor_cmd_decode.sv
module nor_cmd_decode
  import nor_seq_pkg::*;
#(
  parameter int AW = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic              busy,
  input  logic [AW-1:0]     addr,
  input  logic [BYTE_W-1:0] wdata,
  output logic              go_prog,
  output logic              go_chip,
  output logic              go_sect
);
  dec_state_e st, st_nx;
  logic at_k1, at_k2;

  assign at_k1 = (addr[CMD_AW-1:0] == ADR_KEY1);
  assign at_k2 = (addr[CMD_AW-1:0] == ADR_KEY2);

  always_comb begin
    st_nx   = st;
    go_prog = 1'b0;
    go_chip = 1'b0;
    go_sect = 1'b0;
    if (we && !busy) begin
      st_nx = DS_IDLE;
      case (st)
        DS_IDLE:  if (at_k1 && wdata == KEY1) st_nx = DS_K1;
        DS_K1:    if (at_k2 && wdata == KEY2) st_nx = DS_K2;
        DS_K2: begin
          if (at_k1 && wdata == OP_PROG)      st_nx = DS_PADDR;
          else if (at_k1 && wdata == OP_ESET) st_nx = DS_ESET;
        end
        DS_PADDR: go_prog = (wdata != OP_ABORT);
        DS_ESET:  if (at_k1 && wdata == KEY1) st_nx = DS_EK1;
        DS_EK1:   if (at_k2 && wdata == KEY2) st_nx = DS_EK2;
        DS_EK2: begin
          go_chip = at_k1 && (wdata == OP_CHIP);
          go_sect = (wdata == OP_SECT);
        end
        default:  st_nx = DS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) st <= DS_IDLE;
    else     st <= st_nx;
  end

  // R6
  busy_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (we && busy) |=> $stable(st));
endmodule

// File: rtl/nor_embed_engine.sv
module nor_embed_engine
  import nor_seq_pkg::*;
#(
  parameter int ARR_AW    = 6,
  parameter int SEC_W     = 2,
  parameter int PROG_CYC  = 8,
  parameter int ERASE_CYC = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go_prog,
  input  logic              go_chip,
  input  logic              go_sect,
  input  logic [ARR_AW-1:0] cmd_addr,
  input  logic [BYTE_W-1:0] cmd_data,
  input  logic [BYTE_W-1:0] rd_q,
  output logic [ARR_AW-1:0] eng_raddr,
  output logic              wr_en,
  output logic [ARR_AW-1:0] wr_addr,
  output logic [BYTE_W-1:0] wr_data,
  output logic              busy_o,
  output logic              erasing_o,
  output logic              poll7_o
);
  localparam int OFF_W = ARR_AW - SEC_W;
  localparam int WMAX  = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
  localparam int WCW   = $clog2(WMAX + 1);

  eng_state_e        st;
  logic [ARR_AW-1:0] ptr, base, last, tgt;
  logic [BYTE_W-1:0] dat;
  logic [WCW-1:0]    wcnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ES_IDLE;
      busy_o    <= 1'b0;
      erasing_o <= 1'b0;
      ptr       <= '0;
      base      <= '0;
      last      <= '0;
      tgt       <= '0;
      dat       <= '0;
      wcnt      <= '0;
    end else begin
      case (st)
        ES_IDLE: begin
          if (go_prog) begin
            st     <= ES_PWAIT;
            tgt    <= cmd_addr;
            dat    <= cmd_data;
            wcnt   <= WCW'(PROG_CYC - 1);
            busy_o <= 1'b1;
          end else if (go_chip || go_sect) begin
            st        <= ES_ZERO;
            busy_o    <= 1'b1;
            erasing_o <= 1'b1;
            if (go_chip) begin
              ptr  <= '0;
              base <= '0;
              last <= '1;
            end else begin
              ptr  <= {cmd_addr[ARR_AW-1 -: SEC_W], {OFF_W{1'b0}}};
              base <= {cmd_addr[ARR_AW-1 -: SEC_W], {OFF_W{1'b0}}};
              last <= {cmd_addr[ARR_AW-1 -: SEC_W], {OFF_W{1'b1}}};
            end
          end
        end
        ES_PWAIT: begin
          if (wcnt == '0) begin
            st     <= ES_IDLE;
            busy_o <= 1'b0;
          end else wcnt <= wcnt - 1'b1;
        end
        ES_ZERO: begin
          if (ptr == last) begin
            st   <= ES_EWAIT;
            wcnt <= WCW'(ERASE_CYC - 1);
          end else ptr <= ptr + 1'b1;
        end
        ES_EWAIT: begin
          if (wcnt == '0) begin
            st  <= ES_ONE;
            ptr <= base;
          end else wcnt <= wcnt - 1'b1;
        end
        ES_ONE: begin
          if (ptr == last) begin
            st        <= ES_IDLE;
            busy_o    <= 1'b0;
            erasing_o <= 1'b0;
          end else ptr <= ptr + 1'b1;
        end
        default: st <= ES_IDLE;
      endcase
    end
  end

  always_comb begin
    wr_en   = !rst && ((st == ES_ZERO) || (st == ES_ONE) ||
                       (st == ES_PWAIT && wcnt == '0));
    wr_addr = (st == ES_PWAIT) ? tgt : ptr;
    case (st)
      ES_ZERO: wr_data = '0;
      ES_ONE:  wr_data = '1;
      default: wr_data = rd_q & dat;
    endcase
  end

  assign eng_raddr = tgt;
  assign poll7_o   = erasing_o ? 1'b0 : ~dat[BYTE_W-1];

  // R9
  zero_walk_up_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ES_ZERO && $past(st) == ES_ZERO) |-> ptr == $past(ptr) + 1'b1);

  // R3
  busy_state_agree_chk: assert property (@(posedge clk) disable iff (rst)
    busy_o == (st != ES_IDLE));
endmodule

// File: rtl/nor_cell_array.sv
module nor_cell_array #(
  parameter int DW = 8,
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/nor_flash_seq.sv
module nor_flash_seq
  import nor_seq_pkg::*;
#(
  parameter int AW        = 11,
  parameter int ARR_AW    = 6,
  parameter int SEC_W     = 2,
  parameter int PROG_CYC  = 8,
  parameter int ERASE_CYC = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic [AW-1:0]     bus_addr,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  output logic              busy
);
  logic              go_prog, go_chip, go_sect;
  logic              wr_en, erasing, poll7;
  logic [ARR_AW-1:0] eng_raddr, wr_addr, arr_raddr;
  logic [BYTE_W-1:0] wr_data, arr_q, stat_q;
  logic              rsel_q, tog6_q, tog2_q;

  nor_cmd_decode #(.AW(AW)) u_dec (
    .clk(clk), .rst(rst), .we(bus_we), .busy(busy),
    .addr(bus_addr), .wdata(bus_wdata),
    .go_prog(go_prog), .go_chip(go_chip), .go_sect(go_sect)
  );

  nor_embed_engine #(
    .ARR_AW(ARR_AW), .SEC_W(SEC_W),
    .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)
  ) u_eng (
    .clk(clk), .rst(rst),
    .go_prog(go_prog), .go_chip(go_chip), .go_sect(go_sect),
    .cmd_addr(bus_addr[ARR_AW-1:0]), .cmd_data(bus_wdata),
    .rd_q(arr_q), .eng_raddr(eng_raddr),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .busy_o(busy), .erasing_o(erasing), .poll7_o(poll7)
  );

  assign arr_raddr = busy ? eng_raddr : bus_addr[ARR_AW-1:0];

  nor_cell_array #(.DW(BYTE_W), .AW(ARR_AW)) u_arr (
    .clk(clk), .we(wr_en), .waddr(wr_addr), .wdata(wr_data),
    .re(bus_re | busy), .raddr(arr_raddr), .rdata(arr_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsel_q <= 1'b0;
      tog6_q <= 1'b0;
      tog2_q <= 1'b0;
      stat_q <= '0;
    end else if (bus_re) begin
      rsel_q <= busy;
      if (busy) begin
        stat_q <= {poll7, tog6_q, 3'b000, tog2_q, 2'b00};
        tog6_q <= ~tog6_q;
        if (erasing) tog2_q <= ~tog2_q;
      end
    end
  end

  assign bus_rdata = rsel_q ? stat_q : arr_q;

  // R9
  reset_abort_chk: assert property (@(posedge clk) rst |=> !busy);

  // R3
  busy_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(bus_we));
endmodule

// File: tb/nor_flash_seq_tb.sv
`timescale 1ns/1ps
module nor_flash_seq_tb;
  localparam int AW = 11, ARR_AW = 6, SEC_W = 2, PROG_CYC = 8, ERASE_CYC = 20;
  localparam int DEPTH = 1 << ARR_AW;
  localparam int SWORDS = 1 << (ARR_AW - SEC_W);

  logic clk = 1'b0, rst = 1'b1, we = 1'b0, re = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [7:0] wd = '0;
  wire  [7:0] rd;
  wire        busy;
  int checks = 0, errors = 0, cyc = 0;
  logic [7:0] model [DEPTH];

  nor_flash_seq #(.AW(AW), .ARR_AW(ARR_AW), .SEC_W(SEC_W),
    .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)) u_dut (
    .clk(clk), .rst(rst), .bus_we(we), .bus_re(re), .bus_addr(addr),
    .bus_wdata(wd), .bus_rdata(rd), .busy(busy));

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL R3 watchdog act=running exp=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic logic [7:0] prog_val(logic [7:0] old, logic [7:0] d);
    return old & d;
  endfunction

  function automatic int erase_len(int n);
    return 2 * n + ERASE_CYC;
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [AW-1:0] a, logic [7:0] d);
    @(negedge clk); we = 1'b1; addr = a; wd = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rdw(logic [AW-1:0] a, output logic [7:0] v);
    @(negedge clk); re = 1'b1; addr = a;
    @(negedge clk); re = 1'b0; v = rd;
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (busy) begin n++; @(negedge clk); end
  endtask

  task automatic prog(logic [AW-1:0] a, logic [7:0] d);
    wr(11'h555, 8'hAA); wr(11'h2AA, 8'h55); wr(11'h555, 8'hA0); wr(a, d);
  endtask

  task automatic erase_prefix();
    wr(11'h555, 8'hAA); wr(11'h2AA, 8'h55); wr(11'h555, 8'h80);
    wr(11'h555, 8'hAA); wr(11'h2AA, 8'h55);
  endtask

  initial begin
    logic [7:0] v, s1, s2;
    int n;
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    chk("R1 busy after reset", busy, 0);

    // R4 chip erase
    erase_prefix(); wr(11'h555, 8'h10);
    wait_idle(n);
    chk("R3 chip erase length", n, erase_len(DEPTH));
    for (int i = 0; i < DEPTH; i++) begin
      model[i] = 8'hFF;
      rdw(AW'(i), v);
      chk("R4 chip erase word", v, 8'hFF);
    end
    rdw(11'd3, v);
    chk("R1 array read", v, model[3]);

    // R7 status during program, R2 result
    prog(11'd5, 8'h3C);
    rdw(11'd5, s1); rdw(11'd5, s2);
    chk("R7 poll bit", s1 & 8'h80, 8'h80);
    chk("R7 toggle6", (s1 ^ s2) & 8'h40, 8'h40);
    chk("R7 toggle2 held", (s1 ^ s2) & 8'h04, 0);
    chk("R7 zero bits", s1 & 8'h3B, 0);
    wait_idle(n);
    model[5] = prog_val(model[5], 8'h3C);
    rdw(11'd5, v);
    chk("R2 program", v, model[5]);

    // R2 zero cannot become one
    prog(11'd5, 8'hC3);
    wait_idle(n);
    chk("R3 program length", n, PROG_CYC);
    model[5] = prog_val(model[5], 8'hC3);
    rdw(11'd5, v);
    chk("R2 no 0->1", v, 8'h00);

    // R8 broken sequence and cancel
    wr(11'h555, 8'hAA); wr(11'h2AB, 8'h55); wr(11'h555, 8'hA0); wr(11'd7, 8'h00);
    chk("R8 broken no busy", busy, 0);
    rdw(11'd7, v);
    chk("R8 broken no program", v, 8'hFF);
    wr(11'h555, 8'hAA); wr(11'h2AA, 8'h55); wr(11'h555, 8'hA0); wr(11'd9, 8'hF0);
    chk("R8 cancel no busy", busy, 0);
    rdw(11'd9, v);
    chk("R8 cancel no program", v, 8'hFF);
    prog(11'd9, 8'h0F); wait_idle(n);
    model[9] = 8'h0F;
    rdw(11'd9, v);
    chk("R8 idle after cancel", v, 8'h0F);

    // R9 reset abort during sector 1 erase
    erase_prefix(); wr(11'h010, 8'h30);
    repeat (3) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk("R9 busy drops", busy, 0);
    rst = 1'b0;
    rdw(11'h010, v);
    chk("R9 zeroed word", v, 8'h00);
    rdw(11'h01F, v);
    chk("R9 untouched word", v, 8'hFF);
    erase_prefix(); wr(11'h01F, 8'h30);
    wait_idle(n);
    chk("R3 sector erase length", n, erase_len(SWORDS));
    for (int i = SWORDS; i < 2 * SWORDS; i++) begin
      rdw(AW'(i), v);
      chk("R9 reissued erase", v, 8'hFF);
    end

    // R5 sector 0 erase, R6 writes ignored, R7 erase status
    prog(11'h021, 8'h81); wait_idle(n);
    model[33] = 8'h81;
    erase_prefix(); wr(11'h003, 8'h30);
    rdw(11'd0, s1); rdw(11'd0, s2);
    chk("R7 erase poll", s1 & 8'h80, 0);
    chk("R7 erase toggle2", (s1 ^ s2) & 8'h44, 8'h44);
    prog(11'h021, 8'h00);
    wait_idle(n);
    wr(11'h021, 8'h00);
    for (int i = 0; i < SWORDS; i++) model[i] = 8'hFF;
    for (int i = 0; i < 3 * SWORDS; i++) begin
      rdw(AW'(i), v);
      chk("R5 sector erase scope", v, model[i]);
    end
    rdw(11'h021, v);
    chk("R6 write while busy", v, 8'h81);

    // Random mix
    for (int it = 0; it < 200; it++) begin
      int k, a;
      logic [7:0] d;
      k = $urandom % 3; a = $urandom % DEPTH; d = 8'($urandom);
      case (k)
        0: begin
          prog(AW'(a), d); wait_idle(n);
          model[a] = prog_val(model[a], d);
        end
        1: begin
          rdw(AW'(a), v);
          chk("R2 random read", v, model[a]);
        end
        default: begin
          wr(11'h555, 8'hAA); wr(11'h2AA, 8'h54); wr(AW'(a), d);
          chk("R8 random broken", busy, 0);
        end
      endcase
    end
    for (int i = 0; i < DEPTH; i++) begin
      rdw(AW'(i), v);
      chk("R2 final sweep", v, model[i]);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule